// File: doc/BRIEF.md
# Banked Address Decoder with ROM Shadowing

This block is the address glue for a processor with a 24-bit address bus whose upper eight bits appear on the data bus during the low half of each bus cycle. The block captures that bank byte, joins it to the 16-bit address, and drives one chip select out of five targets: RAM, a low ROM segment, a high ROM segment, an I/O window and a small on-chip register window. Outside bank 0 the whole space is flat RAM, so data arrays can run straight across bank boundaries.

Two small control registers shape the bank-0 map and the bus timing. One register holds two flags that remove the low or the high ROM segment from the map, so that reads there reach the RAM underneath. The other register holds the number of wait states that a ROM read gets, from 0 to 3. A write that lands in a ROM range always goes to RAM, whether or not that ROM segment is mapped in, so software can fill the shadow RAM before it switches the ROM out.

Top module: `bank_map_decoder`

## Requirements
- R1: With bank 0 and a valid cycle, addresses 0x0000 to 0xBFFF assert only `selRam`.
- R2: With bank 0, a read cycle and the segment mapped in, 0xC000 to 0xCFFF assert only `selRomLo`, and 0xE000 to 0xFFFF assert only `selRomHi`.
- R3: With bank 0, 0xD000 to 0xD7FF assert only `selIo`, 0xDF00 to 0xDFFF assert only `selRegs`, and 0xD800 to 0xDEFF assert no select.
- R4: With any bank from 0x01 to 0xFF, every 16-bit address asserts only `selRam`, for reads and for writes.
- R5: Register 0 bit 0 set removes the low ROM and bit 1 set removes the high ROM. A read in a removed segment asserts `selRam`. The two flags act independently.
- R6: A write (`rdWrN` = 0) to either ROM range asserts `selRam` and never a ROM select, whatever the register 0 flags hold.
- R7: At each rising `clk` edge where `busPhase` is low, `dataBus` is captured as the bank byte. From the next cycle on, `bankOut` shows the captured byte. While `busPhase` is high, `bankOut` holds its value.
- R8: When `validData` and `validProg` are both low, no select is active. In any cycle, at most one select is active.
- R9: A ROM read access is an unbroken run of cycles that decode as a ROM read. `ready` is low for the first N cycles of that run, where N is register 1 bits 1:0, and high afterwards. RAM, I/O and register accesses never lower `ready`.
- R10: After reset, register 0 reads 0 (both ROM segments mapped in), register 1 reads 3, `bankOut` is 0 and `ready` is high.
- R11: A register write with `regWrEn` high and `regSel` choosing the register (0 or 1) takes effect at the clock edge. `regRdData` shows the register chosen by `regSel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busPhase | input | 1 | Bus clock phase; low while the bank byte is on the data bus |
| dataBus | input | 8 | Processor data bus, carries the bank byte in the low phase |
| addrLo | input | 16 | Processor address bits 15:0 |
| rdWrN | input | 1 | 1 for a read, 0 for a write |
| validData | input | 1 | Processor marks a valid data address |
| validProg | input | 1 | Processor marks a valid program address |
| regSel | input | 1 | Register port select: 0 map flags, 1 wait count |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 2 | Register write data |
| regRdData | output | 2 | Register read data |
| bankOut | output | 8 | Latched bank byte, address bits 23:16 |
| selRam | output | 1 | RAM chip select |
| selRomLo | output | 1 | Low ROM chip select |
| selRomHi | output | 1 | High ROM chip select |
| selIo | output | 1 | I/O window chip select |
| selRegs | output | 1 | Register window chip select |
| ready | output | 1 | Low to stretch a ROM read by a wait state |

## Verification
The selects and the register read data are combinational, so the bench samples them one nanosecond after it drives the inputs on a falling edge. A new bank byte appears on `bankOut` only after the rising edge that captures it, so the bench sets the bank one full cycle ahead of each address. `ready` is checked in every cycle of a ROM read: low in the first cycle when N is nonzero, high in cycle N, and each cycle is sampled after the falling edge that follows the edge that moved the counter. Register writes are read back one cycle after the write strobe.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  // Strobes from the control side to the decode datapath
  typedef struct packed {
    logic hideLo;
    logic hideHi;
  } ctrlStrobe_t;

  // One flag per decoded target
  typedef struct packed {
    logic ram;
    logic romLo;
    logic romHi;
    logic io;
    logic regs;
  } chipSel_t;

  localparam int unsigned CFG_W = 2;

endpackage

// File: rtl/bank_dp.sv
module bank_dp
  import bank_map_pkg::*;
#(
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [15:0] RAM_END     = 16'hBFFF,
  parameter logic [15:0] ROMLO_BASE  = 16'hC000,
  parameter logic [15:0] ROMLO_END   = 16'hCFFF,
  parameter logic [15:0] IO_BASE     = 16'hD000,
  parameter logic [15:0] IO_END      = 16'hD7FF,
  parameter logic [15:0] REGS_BASE   = 16'hDF00,
  parameter logic [15:0] REGS_END    = 16'hDFFF,
  parameter logic [15:0] ROMHI_BASE  = 16'hE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busPhase,
  input  logic [BANK_W-1:0] dataBus,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic              rdWrN,
  input  logic              validData,
  input  logic              validProg,
  input  ctrlStrobe_t       strobe,
  output logic [BANK_W-1:0] bankOut,
  output chipSel_t          chipSel,
  output logic              romRead
);

  localparam logic [BANK_W-1:0] BANK_ZERO = '0;

  logic [BANK_W-1:0] bankQ;
  logic              cycleValid;
  logic              inBank0;
  logic              inRam0, inRomLo, inIo, inRegs, inRomHi;
  chipSel_t          selNext;

  // Bank byte capture during the low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
    end else if (!busPhase) begin
      bankQ <= dataBus;
    end
  end

  assign bankOut = bankQ;

  assign cycleValid = validData | validProg;
  assign inBank0    = (bankQ == BANK_ZERO);

  // Range compares within bank 0
  always_comb begin
    inRam0  = (addrLo <= RAM_END);
    inRomLo = (addrLo >= ROMLO_BASE) && (addrLo <= ROMLO_END);
    inIo    = (addrLo >= IO_BASE) && (addrLo <= IO_END);
    inRegs  = (addrLo >= REGS_BASE) && (addrLo <= REGS_END);
    inRomHi = (addrLo >= ROMHI_BASE);
  end

  always_comb begin
    selNext = '0;
    if (cycleValid) begin
      if (!inBank0) begin
        selNext.ram = 1'b1;
      end else if (inRam0) begin
        selNext.ram = 1'b1;
      end else if (inRomLo) begin
        if (strobe.hideLo || !rdWrN) selNext.ram = 1'b1;
        else                         selNext.romLo = 1'b1;
      end else if (inRomHi) begin
        if (strobe.hideHi || !rdWrN) selNext.ram = 1'b1;
        else                         selNext.romHi = 1'b1;
      end else if (inIo) begin
        selNext.io = 1'b1;
      end else if (inRegs) begin
        selNext.regs = 1'b1;
      end
    end
  end

  assign chipSel = selNext;
  assign romRead = selNext.romLo | selNext.romHi;

  // R8
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chipSel));

  // R8
  idle_nosel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!validData && !validProg) |-> (chipSel == '0));

  // R6
  write_norom_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdWrN |-> (!chipSel.romLo && !chipSel.romHi));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busPhase |=> $stable(bankOut));

  // R4
  upper_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && (bankOut != BANK_ZERO)) |-> chipSel.ram);

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_map_pkg::*;
#(
  parameter int unsigned WAIT_W     = 2,
  parameter int unsigned WAIT_RESET = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  output logic [CFG_W-1:0] regRdData,
  input  logic             romRead,
  output ctrlStrobe_t      strobe,
  output logic             ready
);

  localparam int unsigned MAX_WAIT = (1 << WAIT_W) - 1;
  localparam int unsigned RUN_W    = WAIT_W + 1;

  logic              hideLoQ, hideHiQ;
  logic [WAIT_W-1:0] waitCfg;
  logic [WAIT_W-1:0] waitLeft;
  logic              romReadPrev;
  logic              newAccess;
  logic [RUN_W-1:0]  lowRun;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hideLoQ <= 1'b0;
      hideHiQ <= 1'b0;
      waitCfg <= WAIT_W'(WAIT_RESET);
    end else if (regWrEn) begin
      if (!regSel) begin
        hideLoQ <= regWrData[0];
        hideHiQ <= regWrData[1];
      end else begin
        waitCfg <= regWrData[WAIT_W-1:0];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (!regSel) regRdData = {hideHiQ, hideLoQ};
    else         regRdData[WAIT_W-1:0] = waitCfg;
  end

  assign strobe.hideLo = hideLoQ;
  assign strobe.hideHi = hideHiQ;

  // Wait-state sequencing
  assign newAccess = romRead && !romReadPrev;

  always_comb begin
    if (newAccess) ready = (waitCfg == '0);
    else           ready = !romRead || (waitLeft == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romReadPrev <= 1'b0;
      waitLeft    <= '0;
    end else begin
      romReadPrev <= romRead;
      if (newAccess) begin
        waitLeft <= (waitCfg == '0) ? '0 : waitCfg - 1'b1;
      end else if (romRead && (waitLeft != '0)) begin
        waitLeft <= waitLeft - 1'b1;
      end
    end
  end

  // Length of the current low stretch on ready, for checking only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (!ready) begin
      if (lowRun != '1) lowRun <= lowRun + 1'b1;
    end else begin
      lowRun <= '0;
    end
  end

  // R9
  wait_romonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> romRead);

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (lowRun < RUN_W'(MAX_WAIT)));

  // R11
  map_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel) |=> (strobe.hideLo == $past(regWrData[0])
                              && strobe.hideHi == $past(regWrData[1])));

  // R11
  wait_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel) |=> (waitCfg == $past(regWrData[WAIT_W-1:0])));

endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
  import bank_map_pkg::*;
#(
  parameter int unsigned BANK_W     = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WAIT_W     = 2,
  parameter int unsigned WAIT_RESET = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busPhase,
  input  logic [BANK_W-1:0] dataBus,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic              rdWrN,
  input  logic              validData,
  input  logic              validProg,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [CFG_W-1:0]  regWrData,
  output logic [CFG_W-1:0]  regRdData,
  output logic [BANK_W-1:0] bankOut,
  output logic              selRam,
  output logic              selRomLo,
  output logic              selRomHi,
  output logic              selIo,
  output logic              selRegs,
  output logic              ready
);

  ctrlStrobe_t strobe;
  chipSel_t    chipSel;
  logic        romRead;

  bank_ctrl #(
    .WAIT_W    (WAIT_W),
    .WAIT_RESET(WAIT_RESET)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .romRead  (romRead),
    .strobe   (strobe),
    .ready    (ready)
  );

  bank_dp #(
    .BANK_W(BANK_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busPhase (busPhase),
    .dataBus  (dataBus),
    .addrLo   (addrLo),
    .rdWrN    (rdWrN),
    .validData(validData),
    .validProg(validProg),
    .strobe   (strobe),
    .bankOut  (bankOut),
    .chipSel  (chipSel),
    .romRead  (romRead)
  );

  assign selRam   = chipSel.ram;
  assign selRomLo = chipSel.romLo;
  assign selRomHi = chipSel.romHi;
  assign selIo    = chipSel.io;
  assign selRegs  = chipSel.regs;

endmodule

// File: tb/bank_map_decoder_tb.sv
module bank_map_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busPhase = 1'b1;
  logic [7:0]  dataBus = '0;
  logic [15:0] addrLo = '0;
  logic        rdWrN = 1'b1;
  logic        validData = 1'b0;
  logic        validProg = 1'b0;
  logic        regSel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrData = '0;
  logic [1:0]  regRdData;
  logic [7:0]  bankOut;
  logic        selRam, selRomLo, selRomHi, selIo, selRegs, ready;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  bank_map_decoder u_dut (
    .clk(clk), .rstN(rstN), .busPhase(busPhase), .dataBus(dataBus),
    .addrLo(addrLo), .rdWrN(rdWrN), .validData(validData),
    .validProg(validProg), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .bankOut(bankOut),
    .selRam(selRam), .selRomLo(selRomLo), .selRomHi(selRomHi),
    .selIo(selIo), .selRegs(selRegs), .ready(ready)
  );

  // Select vector order: ram, romLo, romHi, io, regs
  localparam logic [4:0] S_RAM = 5'b10000;
  localparam logic [4:0] S_LO  = 5'b01000;
  localparam logic [4:0] S_HI  = 5'b00100;
  localparam logic [4:0] S_IO  = 5'b00010;
  localparam logic [4:0] S_REG = 5'b00001;
  localparam logic [4:0] S_NONE = 5'b00000;

  // {bank, addr, rdWrN, validData, validProg, expected selects}
  localparam int NVEC = 18;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 16'h0000, 3'b110, S_RAM},
    {8'h00, 16'hBFFF, 3'b110, S_RAM},
    {8'h00, 16'hC000, 3'b110, S_LO},
    {8'h00, 16'hCFFF, 3'b101, S_LO},
    {8'h00, 16'hD000, 3'b110, S_IO},
    {8'h00, 16'hD7FF, 3'b010, S_IO},
    {8'h00, 16'hD800, 3'b110, S_NONE},
    {8'h00, 16'hDEFF, 3'b110, S_NONE},
    {8'h00, 16'hDF00, 3'b110, S_REG},
    {8'h00, 16'hDFFF, 3'b010, S_REG},
    {8'h00, 16'hE000, 3'b110, S_HI},
    {8'h00, 16'hFFFF, 3'b101, S_HI},
    {8'h00, 16'hC123, 3'b010, S_RAM},
    {8'h00, 16'hF000, 3'b010, S_RAM},
    {8'h01, 16'hC000, 3'b110, S_RAM},
    {8'hFF, 16'hE000, 3'b110, S_RAM},
    {8'h7F, 16'hD000, 3'b010, S_RAM},
    {8'h00, 16'hE000, 3'b100, S_NONE}
  };

  function automatic logic [4:0] sels();
    return {selRam, selRomLo, selRomHi, selIo, selRegs};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Capture a bank byte, leave the bus idle, return at a falling edge with busPhase high
  task automatic setBank(input logic [7:0] b);
    @(negedge clk);
    validData = 1'b0; validProg = 1'b0;
    busPhase = 1'b0; dataBus = b;
    @(negedge clk);
    busPhase = 1'b1; dataBus = 8'hA5;
  endtask

  task automatic regWrite(input logic sel, input logic [1:0] d);
    @(negedge clk);
    regSel = sel; regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic access(input logic [15:0] a, input logic rw, input logic vd, input logic vp);
    addrLo = a; rdWrN = rw; validData = vd; validProg = vp;
    #1;
  endtask

  // Check ready over a ROM read at 0xC000 for a given wait count
  task automatic romWait(input logic [1:0] n, input string req);
    regWrite(1'b1, n);
    setBank(8'h00);
    access(16'hC000, 1'b1, 1'b1, 1'b0);
    for (int c = 0; c <= 4; c++) begin
      check(ready == (c >= n), req, ready, (c >= n));
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #100000;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R10 reset state
    regSel = 1'b0; #1;
    check(regRdData == 2'b00, "R10 map flags", regRdData, 0);
    regSel = 1'b1; #1;
    check(regRdData == 2'b11, "R10 wait count", regRdData, 3);
    check(bankOut == 8'h00, "R10 bank", bankOut, 0);
    check(ready == 1'b1, "R10 ready", ready, 1);
    check(sels() == S_NONE, "R10 R8 idle selects", sels(), S_NONE);

    // Decode table: R1 R2 R3 R4 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      setBank(VEC[i][31:24]);
      access(VEC[i][23:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      check(sels() == VEC[i][4:0], $sformatf("R1-table vec %0d", i), sels(), VEC[i][4:0]);
    end

    // R7 capture and hold
    @(negedge clk);
    validData = 1'b0; validProg = 1'b0; busPhase = 1'b0; dataBus = 8'h5A;
    @(negedge clk);
    busPhase = 1'b1; dataBus = 8'h33; #1;
    check(bankOut == 8'h5A, "R7 capture", bankOut, 8'h5A);
    @(negedge clk);
    @(negedge clk); #1;
    check(bankOut == 8'h5A, "R7 hold while phase high", bankOut, 8'h5A);

    // R5 hide low ROM only
    regWrite(1'b0, 2'b01);
    regSel = 1'b0; #1;
    check(regRdData == 2'b01, "R11 readback map", regRdData, 1);
    setBank(8'h00);
    access(16'hC800, 1'b1, 1'b1, 1'b0);
    check(sels() == S_RAM, "R5 low hidden", sels(), S_RAM);
    access(16'hE800, 1'b1, 1'b1, 1'b0);
    check(sels() == S_HI, "R5 high still mapped", sels(), S_HI);
    // R5 hide high ROM only
    regWrite(1'b0, 2'b10);
    setBank(8'h00);
    access(16'hFFFE, 1'b1, 1'b0, 1'b1);
    check(sels() == S_RAM, "R5 high hidden", sels(), S_RAM);
    access(16'hC000, 1'b1, 1'b1, 1'b0);
    check(sels() == S_LO, "R5 low still mapped", sels(), S_LO);
    // R6 write with ROM hidden still RAM
    access(16'hF123, 1'b0, 1'b1, 1'b0);
    check(sels() == S_RAM, "R6 write hidden high", sels(), S_RAM);
    regWrite(1'b0, 2'b00);

    // R11 wait register readback
    regWrite(1'b1, 2'b01);
    regSel = 1'b1; #1;
    check(regRdData == 2'b01, "R11 readback wait", regRdData, 1);

    // R9 wait states
    romWait(2'd0, "R9 wait0");
    romWait(2'd2, "R9 wait2");
    romWait(2'd3, "R9 wait3");
    setBank(8'h00);
    access(16'h1000, 1'b1, 1'b1, 1'b0);
    check(ready == 1'b1, "R9 RAM no wait", ready, 1);
    access(16'hD100, 1'b1, 1'b1, 1'b0);
    check(ready == 1'b1, "R9 IO no wait", ready, 1);
    setBank(8'h00);
    access(16'hE000, 1'b0, 1'b1, 1'b0);
    check(ready == 1'b1, "R9 ROM write no wait", ready, 1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule